// File: doc/BRIEF.md
# DRAM Initialization and Refresh Scheduler

This controller-side block brings an asynchronous RAS/CAS DRAM out of power-up and then keeps it refreshed. When reset is released, the block holds both strobes inactive for a fixed power-up pause. It then runs a burst of initialization refresh cycles without waiting for permission. After that it raises `init_done` and switches to periodic refresh. In that phase it spreads the device's required refresh count evenly across the refresh period.

Every refresh cycle it drives uses CAS-before-RAS, so the device's own row counter selects the row and no address is needed. During normal operation the block requests the memory bus from an access arbiter with a level request and grant. If refresh requests are deferred, they are counted up to a fixed limit. Once the bus is granted, the counted refreshes are replayed back to back.

A `low_power` input switches to the extended refresh period. This lowers the refresh rate by four, and the change takes effect at the next interval reload. All strobe timing is set in clock cycles by parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `ras_n` and `cas_n` both stay high for at least PAUSE_US microseconds, which is CLK_KHZ*PAUSE_US/1000 clocks (10000 at the defaults), before any cycle starts.
- R2: After the pause, exactly INIT_CYCLES (8) refresh cycles run without needing `ref_grant`. During this phase `ref_req` stays low and `init_done` stays low. `init_done` rises only after the precharge of the last initialization cycle.
- R3: Every refresh cycle is CAS-before-RAS. `cas_n` falls CAS_LEAD (2) clocks before `ras_n` falls. `ras_n` stays low for RAS_PULSE (4) clocks with `cas_n` held low, and both rise together. Both then stay high for at least PRECHARGE (3) clocks before the next `cas_n` fall.
- R4: With `low_power`=0, one refresh is due every CLK_KHZ*32/2048 clocks (781 at the defaults). With the grant held high, successive `ras_n` falls are exactly that many clocks apart.
- R5: With `low_power`=1, the interval is CLK_KHZ*128/2048 clocks (3125 at the defaults). A change of `low_power` takes effect at the next interval reload.
- R6: Refreshes that fall due while the grant is low are counted, up to MAX_BACKLOG (8); further ones are discarded. Once granted, all counted refreshes are issued back to back, with consecutive `ras_n` falls CAS_LEAD+RAS_PULSE+PRECHARGE (9) clocks apart.
- R7: `ref_req` is high from the first due refresh until the precharge of the last issued cycle ends. A cycle starts only while `ref_grant` is high. A cycle that has started runs to completion even if the grant drops.
- R8: With nothing due, a high `ref_grant` causes no strobe activity and `ref_req` stays low. Once `init_done` has risen, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| low_power | input | 1 | 1 selects the extended (128 ms) refresh period |
| ref_grant | input | 1 | Arbiter grants the bus to refresh |
| ref_req | output | 1 | Refresh needs or holds the bus |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| init_done | output | 1 | Pause and initialization cycles are complete |

## Verification
The bench denies the grant for a random number of whole refresh intervals, including zero and counts above the backlog limit. It then checks that exactly the deferred number of cycles, capped at the limit, come out back to back. A design that does not saturate would issue extra cycles, and one that drops deferrals would issue too few. The bench also measures the pause, counts the initialization cycles, and times every strobe edge, so a RAS-before-CAS ordering or a shortened precharge would show up. It measures the gap between refreshes in both period modes, which exposes an off-by-one interval or a mode switch that is never picked up.

// File: rtl/dram_ref_pkg.sv
// Shared types for the refresh scheduler: the strobe sequencer states and
// the top-level phases. Assumes nothing beyond SystemVerilog enums.
package dram_ref_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_ACT,
        SEQ_PRE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN
    } phase_t;

endpackage

// File: rtl/dram_ref_interval.sv
// Refresh interval timer. While enabled it pulses tick once every NORM_CLKS
// or LP_CLKS clocks, as chosen by low_power. The mode is sampled whenever
// the counter reloads. Assumes both counts are at least 1.
module dram_ref_interval #(
    parameter int NORM_CLKS = 781,
    parameter int LP_CLKS   = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic low_power,
    output logic tick
);
    localparam int MAXC = (LP_CLKS > NORM_CLKS) ? LP_CLKS : NORM_CLKS;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    // Select the reload value for the active period mode.
    always_comb reload = low_power ? CW'(LP_CLKS - 1) : CW'(NORM_CLKS - 1);

    // Count down and emit one tick per expiry; idle at reload when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= CW'(NORM_CLKS - 1);
            tick <= 1'b0;
        end else if (!en) begin
            cnt  <= reload;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == '0);
            cnt  <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

endmodule

// File: rtl/dram_ref_backlog.sv
// Pending-refresh counter. It counts up on inc and down on dec, and it
// saturates at MAX_BACKLOG, dropping any tick above the cap. Assumes dec is
// asserted only while the count is nonzero.
module dram_ref_backlog #(
    parameter int MAX_BACKLOG = 8,
    parameter int BW          = $clog2(MAX_BACKLOG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [BW-1:0] pending,
    output logic          has_pending
);
    // Track the number of owed refreshes, with a cap at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10: if (pending != BW'(MAX_BACKLOG)) pending <= pending + 1'b1;
                2'b01: if (pending != '0) pending <= pending - 1'b1;
                default: ;
            endcase
        end
    end

    // Flag a nonzero count for the request logic.
    always_comb has_pending = (pending != '0);

endmodule

// File: rtl/dram_cbr_seq.sv
// CAS-before-RAS strobe sequencer. Each accepted start runs CAS_LEAD clocks
// of CAS only, RAS_PULSE clocks of both strobes, and PRECHARGE clocks of
// neither. A start in the final precharge clock chains the next cycle with
// no gap. The strobes are registered. Assumes every count is at least 1.
module dram_cbr_seq
    import dram_ref_pkg::*;
#(
    parameter int CAS_LEAD  = 2,
    parameter int RAS_PULSE = 4,
    parameter int PRECHARGE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready,
    output logic busy,
    output logic ras_n,
    output logic cas_n
);
    localparam int M1   = (CAS_LEAD > RAS_PULSE) ? CAS_LEAD : RAS_PULSE;
    localparam int MAXP = (M1 > PRECHARGE) ? M1 : PRECHARGE;
    localparam int CW   = $clog2(MAXP + 1);

    seq_state_t    state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // Next-state and phase counter logic for one refresh cycle.
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            SEQ_IDLE: if (start) begin
                nxt     = SEQ_LEAD;
                cnt_nxt = CW'(CAS_LEAD - 1);
            end
            SEQ_LEAD: if (cnt == '0) begin
                nxt     = SEQ_ACT;
                cnt_nxt = CW'(RAS_PULSE - 1);
            end else begin
                cnt_nxt = cnt - 1'b1;
            end
            SEQ_ACT: if (cnt == '0) begin
                nxt     = SEQ_PRE;
                cnt_nxt = CW'(PRECHARGE - 1);
            end else begin
                cnt_nxt = cnt - 1'b1;
            end
            SEQ_PRE: if (cnt == '0) begin
                if (start) begin
                    nxt     = SEQ_LEAD;
                    cnt_nxt = CW'(CAS_LEAD - 1);
                end else begin
                    nxt = SEQ_IDLE;
                end
            end else begin
                cnt_nxt = cnt - 1'b1;
            end
            default: nxt = SEQ_IDLE;
        endcase
    end

    // Report when a start would be accepted and whether a cycle is running.
    always_comb begin
        ready = (state == SEQ_IDLE) || (state == SEQ_PRE && cnt == '0);
        busy  = (state != SEQ_IDLE);
    end

    // Register the state and drive glitch-free strobes from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            ras_n <= !(nxt == SEQ_ACT);
            cas_n <= !(nxt == SEQ_LEAD || nxt == SEQ_ACT);
        end
    end

endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM initialization and refresh scheduler (top). The block runs through
// three phases: power-up pause, INIT_CYCLES ungranted CBR cycles, then
// periodic refresh requested from an arbiter with a backlog of at most
// MAX_BACKLOG. Assumes the arbiter leaves the bus alone while ref_req is
// high and ref_grant is high, and ignores the bus until init_done.
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int CLK_KHZ       = 50000,
    parameter int PAUSE_US      = 200,
    parameter int REF_PERIOD_MS = 32,
    parameter int LP_PERIOD_MS  = 128,
    parameter int REF_CYCLES    = 2048,
    parameter int INIT_CYCLES   = 8,
    parameter int CAS_LEAD      = 2,
    parameter int RAS_PULSE     = 4,
    parameter int PRECHARGE     = 3,
    parameter int MAX_BACKLOG   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_power,
    input  logic ref_grant,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic init_done
);
    localparam int PAUSE_CLKS = CLK_KHZ * PAUSE_US / 1000;
    localparam int NORM_CLKS  = CLK_KHZ * REF_PERIOD_MS / REF_CYCLES;
    localparam int LP_CLKS    = CLK_KHZ * LP_PERIOD_MS / REF_CYCLES;
    localparam int PW         = $clog2(PAUSE_CLKS + 1);
    localparam int IW         = $clog2(INIT_CYCLES + 1);
    localparam int BW         = $clog2(MAX_BACKLOG + 1);

    phase_t        phase;
    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_left;
    logic          tick, has_pending, seq_ready, seq_busy, go, accept;
    logic [BW-1:0] pending;

    dram_ref_interval #(
        .NORM_CLKS (NORM_CLKS),
        .LP_CLKS   (LP_CLKS)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (phase == PH_RUN),
        .low_power (low_power),
        .tick      (tick)
    );

    dram_ref_backlog #(
        .MAX_BACKLOG (MAX_BACKLOG),
        .BW          (BW)
    ) backlog_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc         (tick),
        .dec         (accept && phase == PH_RUN),
        .pending     (pending),
        .has_pending (has_pending)
    );

    dram_cbr_seq #(
        .CAS_LEAD  (CAS_LEAD),
        .RAS_PULSE (RAS_PULSE),
        .PRECHARGE (PRECHARGE)
    ) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go),
        .ready (seq_ready),
        .busy  (seq_busy),
        .ras_n (ras_n),
        .cas_n (cas_n)
    );

    // Decide whether a refresh cycle should start in this clock.
    always_comb begin
        go = ((phase == PH_INIT) && (init_left != '0)) ||
             ((phase == PH_RUN) && has_pending && ref_grant);
        accept = go && seq_ready;
    end

    // Step through pause, initialization and run phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_PAUSE;
            pause_cnt <= PW'(PAUSE_CLKS - 1);
            init_left <= IW'(INIT_CYCLES);
        end else begin
            unique case (phase)
                PH_PAUSE: begin
                    if (pause_cnt == '0) phase <= PH_INIT;
                    else                 pause_cnt <= pause_cnt - 1'b1;
                end
                PH_INIT: begin
                    if (accept) init_left <= init_left - 1'b1;
                    if (init_left == '0 && !seq_busy) phase <= PH_RUN;
                end
                default: ;
            endcase
        end
    end

    // Arbiter-facing outputs.
    always_comb begin
        init_done = (phase == PH_RUN);
        ref_req   = (phase == PH_RUN) && (has_pending || seq_busy);
    end

endmodule

// File: rtl/dram_refresh_sched_chk.sv
// Property checker for the refresh scheduler, bound into every instance.
// It watches the ports and the backlog count. It assumes the reset is
// synchronous and active low.
module dram_refresh_sched_chk #(
    parameter int PAUSE_CLKS  = 10000,
    parameter int MAX_BACKLOG = 8,
    parameter int BW          = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          ref_req,
    input logic          ref_grant,
    input logic          init_done,
    input logic [BW-1:0] pending
);
    localparam int SW = $clog2(PAUSE_CLKS + 1);

    logic [SW-1:0] since;

    // Count clocks since reset release, saturating at the pause length.
    always_ff @(posedge clk) begin
        if (!rst_n)                       since <= '0;
        else if (since != SW'(PAUSE_CLKS)) since <= since + 1'b1;
    end

    assert_quiet_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since < SW'(PAUSE_CLKS)) |-> (ras_n && cas_n));

    assert_no_req_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);

    assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    assert_cas_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    assert_backlog_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= BW'(MAX_BACKLOG));

    assert_start_needs_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && $fell(cas_n)) |-> $past(ref_grant));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .PAUSE_CLKS  (PAUSE_CLKS),
    .MAX_BACKLOG (MAX_BACKLOG),
    .BW          (BW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .ref_req   (ref_req),
    .ref_grant (ref_grant),
    .init_done (init_done),
    .pending   (pending)
);

// File: tb/dram_refresh_sched_tb_top.sv
// Self-checking bench: directed phases plus seeded random grant denials.
module dram_refresh_sched_tb_top;
    localparam int CLK_KHZ   = 50000;
    localparam int PAUSE     = CLK_KHZ * 200 / 1000;
    localparam int NORM      = CLK_KHZ * 32 / 2048;
    localparam int LP        = CLK_KHZ * 128 / 2048;
    localparam int INIT_N    = 8;
    localparam int LEAD      = 2;
    localparam int PULSE     = 4;
    localparam int PRE       = 3;
    localparam int CYC_LEN   = LEAD + PULSE + PRE;
    localparam int MAXB      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic low_power = 1'b0;
    logic ref_grant = 1'b0;
    logic ref_req, ras_n, cas_n, init_done;

    always #10 clk = ~clk;

    dram_refresh_sched dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_power (low_power),
        .ref_grant (ref_grant),
        .ref_req   (ref_req),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .init_done (init_done)
    );

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Strobe monitor, sampled on the falling edge.
    int     fall_cnt = 0;
    int     rise_cnt = 0;
    int     init_falls = 0;
    longint last_fall = -1;
    longint prev_fall = -1;
    longint first_cas_fall = -1;
    logic   p_ras = 1'b1;
    logic   p_cas = 1'b1;
    int     cas_run = 0;
    int     ras_run = 0;
    int     hi_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                chk(cas_run == LEAD, "R3 cas lead", cas_run, LEAD);
                prev_fall = last_fall;
                last_fall = cyc;
                fall_cnt++;
                if (!init_done) init_falls++;
            end
            if (!p_ras && ras_n) begin
                chk(ras_run == PULSE, "R3 ras pulse", ras_run, PULSE);
                chk(cas_n == 1'b1, "R3 cas rises with ras", cas_n, 1);
                rise_cnt++;
            end
            if (p_cas && !cas_n) begin
                if (first_cas_fall < 0) first_cas_fall = cyc;
                else chk(hi_run >= PRE, "R3 precharge", hi_run, PRE);
            end
            ras_run = !ras_n ? ras_run + 1 : 0;
            if (cas_n) cas_run = 0;
            else if (ras_n) cas_run++;
            hi_run = (ras_n && cas_n) ? hi_run + 1 : 0;
            p_ras = ras_n;
            p_cas = cas_n;
        end
    end

    task automatic wait_fall();
        int n0;
        n0 = fall_cnt;
        while (fall_cnt == n0) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 190000);
        wrap_up();
    end

    initial begin
        longint rel;
        void'($urandom(32'd20511));

        repeat (3) @(negedge clk);
        chk(ras_n === 1'b1 && cas_n === 1'b1, "R1 reset strobes high", {ras_n, cas_n}, 3);
        chk(init_done === 1'b0, "R2 reset init_done low", init_done, 0);
        chk(ref_req === 1'b0, "R7 reset ref_req low", ref_req, 0);

        rst_n = 1'b1;
        rel = cyc;
        while (!init_done) @(negedge clk);
        chk(first_cas_fall - rel >= PAUSE, "R1 pause length", first_cas_fall - rel, PAUSE);
        chk(init_falls == INIT_N, "R2 init cycle count", init_falls, INIT_N);
        chk(ref_req == 1'b0, "R8 no request right after init", ref_req, 0);

        // Normal interval with grant held high (R4).
        ref_grant = 1'b1;
        wait_fall();
        for (int i = 0; i < 2; i++) begin
            wait_fall();
            chk(last_fall - prev_fall == NORM, "R4 normal interval", last_fall - prev_fall, NORM);
        end

        // Extended interval in low-power mode, then back (R5).
        low_power = 1'b1;
        wait_fall();
        wait_fall();
        for (int i = 0; i < 2; i++) begin
            wait_fall();
            chk(last_fall - prev_fall == LP, "R5 low-power interval", last_fall - prev_fall, LP);
        end
        low_power = 1'b0;
        wait_fall();
        wait_fall();
        wait_fall();
        chk(last_fall - prev_fall == NORM, "R5 back to normal interval", last_fall - prev_fall, NORM);

        // Grant denial for k whole intervals: backlog replay and saturation (R6, R7, R8).
        for (int t = 0; t < 8; t++) begin
            int k;
            int n0;
            int r0;
            int got;
            int exp_n;
            k = (t == 0) ? 0 : (t == 1) ? MAXB : (t == 2) ? MAXB + 2 : int'($urandom_range(MAXB + 2, 1));
            wait_fall();
            r0 = rise_cnt;
            ref_grant = 1'b0;
            @(negedge clk);
            chk(ref_req == 1'b1, "R7 request held during cycle", ref_req, 1);
            repeat (k * NORM + NORM / 2 - 1) @(negedge clk);
            chk(rise_cnt == r0 + 1, "R7 cycle completes after grant drop", rise_cnt - r0, 1);
            if (k == 0) chk(ref_req == 1'b0, "R8 nothing due, no request", ref_req, 0);
            else        chk(ref_req == 1'b1, "R7 request while deferred", ref_req, 1);
            n0 = fall_cnt;
            ref_grant = 1'b1;
            repeat (300) @(negedge clk);
            got = fall_cnt - n0;
            exp_n = (k < MAXB) ? k : MAXB;
            chk(got == exp_n, "R6 replayed backlog count", got, exp_n);
            if (got >= 2)
                chk(last_fall - prev_fall == CYC_LEN, "R6 back-to-back spacing", last_fall - prev_fall, CYC_LEN);
            chk(ref_req == 1'b0, "R7 request drops after last cycle", ref_req, 0);
        end

        chk(init_done == 1'b1, "R8 init_done stays high", init_done, 1);
        wrap_up();
    end

endmodule